// File: doc/BRIEF.md
# Burst DMA Write Packer

This block sits between a streaming data producer and a memory write port whose clock is unrelated to the producer's. Words are offered on a valid/ready stream with an end-of-transfer flag. They cross into the memory clock domain through a dual-clock FIFO and are packed into a burst buffer. A write request is raised toward memory only when a buffer holds a complete fixed-length burst. Each granted request is followed by exactly one burst of data.

A transfer that ends early, flagged by the last marker before the burst is full, is completed with filler words. Filler words carry zero data and all byte enables cleared, so memory keeps its contents at those positions. A transfer that reaches the burst length without a last marker closes the burst by itself. Burst addresses start at a configured base and advance by one burst length per request. With two buffers, the next burst fills while the current one drains. A one-cycle done pulse marks the acceptance of each burst's final word.

Top module: `burst_wr_packer`

## Requirements
- R1: While either reset is held and directly after it, mem_req, mem_wvalid and mem_done are 0, and src_ready is 1 once the source-side reset is released.
- R2: Words accepted on the source side (src_valid and src_ready both 1 at a src_clk rising edge) reach mem_wdata in acceptance order, with no loss or duplication, across the two unrelated clocks.
- R3: mem_req rises only after every word of that burst has been accepted on the source side. Once raised, mem_req stays 1 with mem_addr unchanged until a cycle in which mem_ack is 1, and it drops in the following cycle.
- R4: After each acknowledged request, exactly BURST_LEN words are offered with mem_wvalid. mem_wvalid is never 1 while mem_req is 1. A word advances only at a rising edge where mem_wvalid and mem_wready are both 1, and otherwise mem_wdata holds.
- R5: A data word carries the source value on mem_wdata, with every bit of mem_wbe set to 1.
- R6: When src_last marks word k of a burst with k < BURST_LEN, the remaining BURST_LEN-k slots are sent as filler words with mem_wdata = 0 and mem_wbe = 0.
- R7: A transfer that reaches BURST_LEN words without src_last closes the burst at BURST_LEN words. The next word starts a new burst.
- R8: The first burst uses address START_ADDR, and each later burst uses the previous address plus BURST_LEN (word units).
- R9: mem_done is 1 for exactly one cycle, the cycle right after the rising edge that accepts the final word of a burst, and is 0 otherwise.
- R10: With NUM_BANKS = 2, if the next burst is already fully buffered when a burst finishes, its mem_req rises in the cycle after the mem_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-side clock |
| src_rst_n | input | 1 | Source-side asynchronous reset, active low |
| src_valid | input | 1 | Source word offered |
| src_ready | output | 1 | FIFO can take a word |
| src_data | input | DATA_W | Source word |
| src_last | input | 1 | Marks the final word of a transfer |
| mem_clk | input | 1 | Memory-side clock |
| mem_rst_n | input | 1 | Memory-side asynchronous reset, active low |
| mem_req | output | 1 | Burst write address request |
| mem_addr | output | ADDR_W | Burst start address, in words |
| mem_ack | input | 1 | Request accepted by memory |
| mem_wvalid | output | 1 | Write word present |
| mem_wready | input | 1 | Memory takes the write word |
| mem_wdata | output | DATA_W | Write word |
| mem_wbe | output | DATA_W/8 | Byte enables; all 1 for data, all 0 for filler |
| mem_done | output | 1 | One-cycle pulse after a burst's final word is taken |

## Verification
Every transfer length from one word up to the full burst is sent with a last marker. This separates a correct filler count and a correct zero-enable boundary from an off-by-one at either end. The sweep is repeated with memory-side readiness always on, on every other cycle and on every third cycle, and with request grants delayed by zero to two cycles. These runs expose data that moves without a handshake and requests that do not hold. Full-length transfers without a last marker test that a burst closes on count alone. A back-to-back group against a slow memory side tests that the second buffer is filled during a drain, by timing each new request against the previous done pulse.

// File: rtl/dmapk_pkg.sv
package dmapk_pkg;

   typedef enum logic [1:0] {
      ISS_IDLE = 2'd0,
      ISS_REQ  = 2'd1,
      ISS_DATA = 2'd2
   } iss_state_e;

   typedef enum logic {
      FILL_TAKE = 1'b0,
      FILL_PAD  = 1'b1
   } fill_state_e;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/dmapk_sync.sv
module dmapk_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dmapk_afifo.sv
module dmapk_afifo #(
   parameter int DW          = 8,
   parameter int DEPTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wr_valid,
   output logic          wr_ready,
   input  logic [DW-1:0] wr_data,
   input  logic          rclk,
   input  logic          rrst_n,
   output logic          rd_valid,
   input  logic          rd_take,
   output logic [DW-1:0] rd_data
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   logic [DW-1:0] store [DEPTH];
   logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
   logic [PW-1:0] rgray_at_w, wgray_at_r;
   logic [PW-1:0] wbin_nx, rbin_nx;
   logic          full, push, pop;

   // write side
   assign full     = (wgray_q == {~rgray_at_w[PW-1:PW-2], rgray_at_w[PW-3:0]});
   assign wr_ready = ~full;
   assign push     = wr_valid & ~full;
   assign wbin_nx  = wbin_q + PW'(1);

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin_q  <= '0;
         wgray_q <= '0;
      end else if (push) begin
         wbin_q  <= wbin_nx;
         wgray_q <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   always_ff @(posedge wclk) begin
      if (push) begin
         store[wbin_q[AW-1:0]] <= wr_data;
      end
   end

   // read side
   assign rd_valid = (rgray_q != wgray_at_r);
   assign pop      = rd_take & rd_valid;
   assign rbin_nx  = rbin_q + PW'(1);
   assign rd_data  = store[rbin_q[AW-1:0]];

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin_q  <= '0;
         rgray_q <= '0;
      end else if (pop) begin
         rbin_q  <= rbin_nx;
         rgray_q <= rbin_nx ^ (rbin_nx >> 1);
      end
   end

   dmapk_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_at_w)
   );

   dmapk_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_at_r)
   );

   AST_GRAY_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
      $countones(wgray_q ^ $past(wgray_q)) <= 1); // R2
   AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
      rd_take |-> rd_valid); // R2

endmodule

// File: rtl/dmapk_bank.sv
module dmapk_bank #(
   parameter  int DW    = 32,
   parameter  int LEN   = 64,
   parameter  int NBANK = 2,
   localparam int BKW   = dmapk_pkg::idx_w(NBANK),
   localparam int IW    = dmapk_pkg::idx_w(LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BKW-1:0]   wr_bank,
   input  logic [IW-1:0]    wr_idx,
   input  logic [DW-1:0]    wr_data,
   input  logic             wr_keep,
   input  logic             set_full,
   input  logic [BKW-1:0]   rd_bank,
   input  logic [IW-1:0]    rd_idx,
   output logic [DW-1:0]    rd_data,
   output logic             rd_keep,
   input  logic             clr_full,
   output logic [NBANK-1:0] full_o
);

   localparam int SLOTS = NBANK * LEN;
   localparam int MW    = dmapk_pkg::idx_w(SLOTS);

   logic [DW-1:0] data_mem [SLOTS];
   logic          keep_mem [SLOTS];
   logic [MW-1:0] waddr, raddr;

   generate
      if (NBANK == 1) begin : g_single
         assign waddr = wr_idx;
         assign raddr = rd_idx;
      end else begin : g_multi
         assign waddr = {wr_bank, wr_idx};
         assign raddr = {rd_bank, rd_idx};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) begin
         data_mem[waddr] <= wr_data;
         keep_mem[waddr] <= wr_keep;
      end
   end

   assign rd_data = data_mem[raddr];
   assign rd_keep = keep_mem[raddr];

   genvar b;
   generate
      for (b = 0; b < NBANK; b++) begin : g_flag
         logic full_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               full_r <= 1'b0;
            end else if (set_full && (wr_bank == BKW'(b))) begin
               full_r <= 1'b1;
            end else if (clr_full && (rd_bank == BKW'(b))) begin
               full_r <= 1'b0;
            end
         end
         assign full_o[b] = full_r;
      end
   endgenerate

   AST_SET_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      set_full |-> !full_o[wr_bank]); // R3
   AST_CLR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      clr_full |-> full_o[rd_bank]); // R4

endmodule

// File: rtl/dmapk_fill.sv
module dmapk_fill
   import dmapk_pkg::*;
#(
   parameter  int DW    = 32,
   parameter  int LEN   = 64,
   parameter  int NBANK = 2,
   localparam int BKW   = dmapk_pkg::idx_w(NBANK),
   localparam int IW    = dmapk_pkg::idx_w(LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_valid,
   input  logic [DW:0]      fifo_word,
   output logic             fifo_take,
   input  logic [NBANK-1:0] full_i,
   output logic             wr_en,
   output logic [BKW-1:0]   wr_bank,
   output logic [IW-1:0]    wr_idx,
   output logic [DW-1:0]    wr_data,
   output logic             wr_keep,
   output logic             set_full
);

   fill_state_e    state_q, state_d;
   logic [IW-1:0]  idx_q, idx_d;
   logic [BKW-1:0] bank_q, bank_d, bank_step;
   logic           last_slot, bank_free;

   generate
      if (NBANK == 1) begin : g_one_bank
         assign bank_step = '0;
      end else begin : g_two_bank
         assign bank_step = bank_q + 1'b1;
      end
   endgenerate

   assign last_slot = (idx_q == IW'(LEN - 1));
   assign bank_free = ~full_i[bank_q];
   assign wr_bank   = bank_q;
   assign wr_idx    = idx_q;

   always_comb begin
      fifo_take = 1'b0;
      wr_en     = 1'b0;
      wr_data   = '0;
      wr_keep   = 1'b0;
      set_full  = 1'b0;
      state_d   = state_q;
      idx_d     = idx_q;
      bank_d    = bank_q;
      case (state_q)
         FILL_TAKE: begin
            if (fifo_valid && bank_free) begin
               fifo_take = 1'b1;
               wr_en     = 1'b1;
               wr_data   = fifo_word[DW-1:0];
               wr_keep   = 1'b1;
               if (last_slot) begin
                  set_full = 1'b1;
                  idx_d    = '0;
                  bank_d   = bank_step;
               end else begin
                  idx_d = idx_q + 1'b1;
                  if (fifo_word[DW]) begin
                     state_d = FILL_PAD;
                  end
               end
            end
         end
         FILL_PAD: begin
            wr_en = 1'b1;
            if (last_slot) begin
               set_full = 1'b1;
               idx_d    = '0;
               bank_d   = bank_step;
               state_d  = FILL_TAKE;
            end else begin
               idx_d = idx_q + 1'b1;
            end
         end
         default: state_d = FILL_TAKE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FILL_TAKE;
         idx_q   <= '0;
         bank_q  <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         bank_q  <= bank_d;
      end
   end

   AST_FILL_OWNS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full_i[bank_q]); // R3
   AST_PAD_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FILL_PAD) |-> !fifo_take); // R6

endmodule

// File: rtl/dmapk_issue.sv
module dmapk_issue
   import dmapk_pkg::*;
#(
   parameter  int             DW         = 32,
   parameter  int             AW         = 32,
   parameter  int             LEN        = 64,
   parameter  int             NBANK      = 2,
   parameter  logic [AW-1:0]  START_ADDR = '0,
   localparam int             BKW        = dmapk_pkg::idx_w(NBANK),
   localparam int             IW         = dmapk_pkg::idx_w(LEN),
   localparam int             BEW        = DW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBANK-1:0] full_i,
   output logic [BKW-1:0]   rd_bank,
   output logic [IW-1:0]    rd_idx,
   input  logic [DW-1:0]    rd_data,
   input  logic             rd_keep,
   output logic             clr_full,
   output logic             mem_req,
   output logic [AW-1:0]    mem_addr,
   input  logic             mem_ack,
   output logic             mem_wvalid,
   output logic [DW-1:0]    mem_wdata,
   output logic [BEW-1:0]   mem_wbe,
   input  logic             mem_wready,
   output logic             mem_done
);

   localparam logic [AW-1:0] LEN_A = AW'(LEN);

   iss_state_e     state_q;
   logic [IW-1:0]  idx_q;
   logic [BKW-1:0] bank_q, bank_step;
   logic [AW-1:0]  addr_q;
   logic           done_q;
   logic           beat, final_beat;

   generate
      if (NBANK == 1) begin : g_one_bank
         assign bank_step = '0;
      end else begin : g_two_bank
         assign bank_step = bank_q + 1'b1;
      end
   endgenerate

   assign mem_req    = (state_q == ISS_REQ);
   assign mem_wvalid = (state_q == ISS_DATA);
   assign mem_addr   = addr_q;
   assign mem_wdata  = rd_data;
   assign mem_wbe    = {BEW{rd_keep}};
   assign mem_done   = done_q;
   assign rd_bank    = bank_q;
   assign rd_idx     = idx_q;
   assign beat       = mem_wvalid & mem_wready;
   assign final_beat = beat & (idx_q == IW'(LEN - 1));
   assign clr_full   = final_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ISS_IDLE;
         idx_q   <= '0;
         bank_q  <= '0;
         addr_q  <= START_ADDR;
         done_q  <= 1'b0;
      end else begin
         done_q <= final_beat;
         case (state_q)
            ISS_IDLE: begin
               if (full_i[bank_q]) begin
                  state_q <= ISS_REQ;
               end
            end
            ISS_REQ: begin
               if (mem_ack) begin
                  state_q <= ISS_DATA;
                  idx_q   <= '0;
               end
            end
            ISS_DATA: begin
               if (final_beat) begin
                  state_q <= ISS_IDLE;
                  idx_q   <= '0;
                  bank_q  <= bank_step;
                  addr_q  <= addr_q + LEN_A;
               end else if (beat) begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= ISS_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R3
   AST_REQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> full_i[bank_q]); // R3
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_wdata) && $stable(mem_wbe))); // R4
   AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_done |-> $past(mem_wvalid && mem_wready)); // R9
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_done |-> (mem_addr == $past(mem_addr) + LEN_A)); // R8

endmodule

// File: rtl/burst_wr_packer.sv
module burst_wr_packer #(
   parameter int                 DATA_W      = 32,
   parameter int                 ADDR_W      = 32,
   parameter int                 BURST_LEN   = 64,
   parameter int                 FIFO_DEPTH  = 16,
   parameter int                 SYNC_STAGES = 2,
   parameter int                 NUM_BANKS   = 2,
   parameter logic [ADDR_W-1:0]  START_ADDR  = '0
) (
   input  logic                  src_clk,
   input  logic                  src_rst_n,
   input  logic                  src_valid,
   output logic                  src_ready,
   input  logic [DATA_W-1:0]     src_data,
   input  logic                  src_last,
   input  logic                  mem_clk,
   input  logic                  mem_rst_n,
   output logic                  mem_req,
   output logic [ADDR_W-1:0]     mem_addr,
   input  logic                  mem_ack,
   output logic                  mem_wvalid,
   input  logic                  mem_wready,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic [DATA_W/8-1:0]   mem_wbe,
   output logic                  mem_done
);

   localparam int BKW = dmapk_pkg::idx_w(NUM_BANKS);
   localparam int IW  = dmapk_pkg::idx_w(BURST_LEN);

   generate
      if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_len
         $error("BURST_LEN must be a power of two of at least 2");
      end
      if (FIFO_DEPTH < 4 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 4");
      end
      if (NUM_BANKS != 1 && NUM_BANKS != 2) begin : g_bad_banks
         $error("NUM_BANKS must be 1 or 2");
      end
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                  fifo_valid, fifo_take;
   logic [DATA_W:0]       fifo_word;
   logic                  wr_en, wr_keep, set_full, clr_full, rd_keep;
   logic [BKW-1:0]        wr_bank, rd_bank;
   logic [IW-1:0]         wr_idx, rd_idx;
   logic [DATA_W-1:0]     wr_data, rd_data;
   logic [NUM_BANKS-1:0]  full;

   dmapk_afifo #(.DW(DATA_W + 1), .DEPTH(FIFO_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
      .wclk(src_clk), .wrst_n(src_rst_n), .wr_valid(src_valid), .wr_ready(src_ready),
      .wr_data({src_last, src_data}),
      .rclk(mem_clk), .rrst_n(mem_rst_n), .rd_valid(fifo_valid), .rd_take(fifo_take),
      .rd_data(fifo_word)
   );

   dmapk_fill #(.DW(DATA_W), .LEN(BURST_LEN), .NBANK(NUM_BANKS)) u_fill (
      .clk(mem_clk), .rst_n(mem_rst_n),
      .fifo_valid(fifo_valid), .fifo_word(fifo_word), .fifo_take(fifo_take),
      .full_i(full), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
      .wr_data(wr_data), .wr_keep(wr_keep), .set_full(set_full)
   );

   dmapk_bank #(.DW(DATA_W), .LEN(BURST_LEN), .NBANK(NUM_BANKS)) u_bank (
      .clk(mem_clk), .rst_n(mem_rst_n),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
      .wr_keep(wr_keep), .set_full(set_full),
      .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data), .rd_keep(rd_keep),
      .clr_full(clr_full), .full_o(full)
   );

   dmapk_issue #(.DW(DATA_W), .AW(ADDR_W), .LEN(BURST_LEN), .NBANK(NUM_BANKS),
                 .START_ADDR(START_ADDR)) u_issue (
      .clk(mem_clk), .rst_n(mem_rst_n),
      .full_i(full), .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
      .rd_keep(rd_keep), .clr_full(clr_full),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .mem_wbe(mem_wbe),
      .mem_wready(mem_wready), .mem_done(mem_done)
   );

   AST_NO_BEAT_IN_REQ: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
      mem_req |-> !mem_wvalid); // R4

endmodule

// File: tb/burst_wr_packer_tb_top.sv
`timescale 1ns/1ps
module burst_wr_packer_tb_top;

   localparam int DW  = 16;
   localparam int AW  = 16;
   localparam int LEN = 8;
   localparam logic [AW-1:0] BASE = 16'h0100;

   logic          src_clk = 1'b0, mem_clk = 1'b0;
   logic          src_rst_n = 1'b0, mem_rst_n = 1'b0;
   logic          src_valid = 1'b0, src_last = 1'b0;
   logic [DW-1:0] src_data = '0;
   logic          src_ready;
   logic          mem_req, mem_wvalid, mem_done;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [1:0]    mem_wbe;
   logic          mem_ack = 1'b0, mem_wready = 1'b0;

   always #10 mem_clk = ~mem_clk;   // 50 MHz
   always #13 src_clk = ~src_clk;

   burst_wr_packer #(.DATA_W(DW), .ADDR_W(AW), .BURST_LEN(LEN), .FIFO_DEPTH(8),
                     .SYNC_STAGES(2), .NUM_BANKS(2), .START_ADDR(BASE)) dut_i (
      .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
      .src_ready(src_ready), .src_data(src_data), .src_last(src_last),
      .mem_clk(mem_clk), .mem_rst_n(mem_rst_n), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_wvalid(mem_wvalid),
      .mem_wready(mem_wready), .mem_wdata(mem_wdata), .mem_wbe(mem_wbe),
      .mem_done(mem_done)
   );

   int tests = 0, fails = 0;
   int lens [64];
   int cum [64];
   bit uses_last [64];
   bit chk_gap [64];
   int stx = 0, mtx = 0, widx = 0, sent_words = 0;
   int mode = 0, ack_delay = 0;
   int cyc = 0, last_done_cyc = -100, req_wait = 0;
   bit req_seen = 1'b0, exp_done = 1'b0, mon_en = 1'b0, finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // memory-side model and monitor, all at the falling edge
   always @(negedge mem_clk) begin
      if (mon_en) begin
         cyc++;
         // R9: done pulse exactly one cycle after the final beat
         if (exp_done || mem_done)
            chk(mem_done == exp_done, "R9", "done pulse", 32'(mem_done), 32'(exp_done));
         if (exp_done) last_done_cyc = cyc;
         exp_done = 1'b0;
         if (mem_req && mem_wvalid)
            chk(1'b0, "R4", "wvalid during request", 32'(mem_wvalid), 32'd0);
         if (mem_req) begin
            if (!req_seen) begin
               req_seen = 1'b1;
               req_wait = 0;
               chk(mem_addr == BASE + 16'(mtx * LEN), "R8", "burst address",
                   32'(mem_addr), 32'(BASE + 16'(mtx * LEN)));
               chk(sent_words >= cum[mtx], "R3", "request before burst buffered",
                   32'(sent_words), 32'(cum[mtx]));
               if (chk_gap[mtx])
                  chk(cyc - last_done_cyc == 1, "R10", "request after done gap",
                      32'(cyc - last_done_cyc), 32'd1);
            end
            mem_ack = (req_wait >= ack_delay);
            req_wait++;
         end else begin
            mem_ack  = 1'b0;
            req_seen = 1'b0;
         end
         case (mode)
            0:       mem_wready = 1'b1;
            1:       mem_wready = (cyc % 2) == 0;
            2:       mem_wready = (cyc % 3) == 0;
            default: mem_wready = (cyc % 4) == 0;
         endcase
         if (mem_wvalid && mem_wready) begin
            logic [DW-1:0] ed;
            logic [1:0]    eb;
            string         tag;
            if (widx < lens[mtx]) begin
               ed  = {mtx[7:0], widx[7:0]};
               eb  = 2'b11;
               tag = (lens[mtx] == LEN && !uses_last[mtx]) ? "R7" : "R2/R5";
            end else begin
               ed  = '0;
               eb  = 2'b00;
               tag = "R6";
            end
            chk(mem_wdata == ed && mem_wbe == eb, tag, "word {be,data}",
                {14'd0, mem_wbe, mem_wdata}, {14'd0, eb, ed});
            widx++;
            if (widx == LEN) begin
               widx = 0;
               mtx++;
               exp_done = 1'b1;
            end
         end
      end
   end

   task automatic send_txn(input int len, input bit with_last);
      lens[stx]      = len;
      uses_last[stx] = with_last;
      cum[stx]       = ((stx > 0) ? cum[stx-1] : 0) + len;
      for (int i = 0; i < len; i++) begin
         @(negedge src_clk);
         src_valid = 1'b1;
         src_data  = {8'(stx), 8'(i)};
         src_last  = with_last && (i == len - 1);
         while (!src_ready) @(negedge src_clk);
         @(posedge src_clk);
         sent_words++;
      end
      @(negedge src_clk);
      src_valid = 1'b0;
      src_last  = 1'b0;
      stx++;
   endtask

   task automatic wait_idle();
      while (mtx < stx) @(negedge mem_clk);
      repeat (3) @(negedge mem_clk);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int t = 0; t < 64; t++) begin
         chk_gap[t] = 1'b0;
         lens[t] = LEN;
         cum[t] = 0;
         uses_last[t] = 1'b0;
      end
      repeat (4) @(negedge mem_clk);
      // R1: outputs idle while reset held
      chk(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 32'd0);
      chk(mem_wvalid == 1'b0, "R1", "mem_wvalid in reset", 32'(mem_wvalid), 32'd0);
      chk(mem_done == 1'b0, "R1", "mem_done in reset", 32'(mem_done), 32'd0);
      @(negedge src_clk); src_rst_n = 1'b1;
      @(negedge mem_clk); mem_rst_n = 1'b1;
      repeat (3) @(negedge src_clk);
      chk(src_ready == 1'b1, "R1", "src_ready after reset", 32'(src_ready), 32'd1);
      @(negedge mem_clk);
      chk(mem_req == 1'b0 && mem_wvalid == 1'b0, "R1", "idle after reset",
          {30'd0, mem_req, mem_wvalid}, 32'd0);
      mon_en = 1'b1;

      // R5, R6: every length with a last marker, three readiness patterns
      for (int m = 0; m < 3; m++) begin
         mode      = m;
         ack_delay = m;
         for (int l = 1; l <= LEN; l++) send_txn(l, 1'b1);
         wait_idle();
      end

      // R7: full-length transfers with no last marker
      mode = 0; ack_delay = 1;
      send_txn(LEN, 1'b0);
      send_txn(LEN, 1'b0);
      wait_idle();

      // R10: back-to-back bursts against a slow memory side
      mode = 3; ack_delay = 0;
      chk_gap[stx + 1] = 1'b1;
      chk_gap[stx + 2] = 1'b1;
      send_txn(LEN, 1'b1);
      send_txn(LEN, 1'b1);
      send_txn(LEN, 1'b1);
      wait_idle();

      chk(mtx == stx, "R4", "bursts completed", 32'(mtx), 32'(stx));
      chk(mem_req == 1'b0 && mem_wvalid == 1'b0, "R4", "idle at end",
          {30'd0, mem_req, mem_wvalid}, 32'd0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule